// File: doc/BRIEF.md
# Persistence-Filtered Temperature Limit Interrupt

This block watches a stream of temperature conversion results and raises an active-low interrupt when the temperature stays outside a programmable window. Each conversion arrives as a one-cycle strobe with an 8-bit two's-complement value. The value is compared against a signed high limit and a signed low limit. A limit is only reported after it has been crossed on three conversions in a row. Each limit path then sets its own sticky status bit, and unless that path is masked, the interrupt is pulled low.

When software issues a clear, both status bits drop and the interrupt releases. A path that has fired stays disarmed until it has seen three conversions in a row on the good side of its own limit. A violation that simply continues after the clear therefore does not bring the interrupt straight back. Once the path is rearmed, a fresh run of three violations reports again.

An external thermal-alarm line, active low, also pulls the interrupt low for as long as it is asserted. This does not depend on the masks or on the filters.

Top module: `templim_irq`

## Requirements
- R1: The high path counts a conversion as a violation when the signed temperature is strictly greater than the signed high limit. On the third consecutive violating conversion, status bit 0 is set one cycle after that strobe. Values compare as two's complement, so a negative temperature never trips the high limit.
- R2: The low path counts a conversion as a violation when the signed temperature is strictly less than the signed low limit. On the third consecutive violating conversion, status bit 1 is set one cycle after that strobe.
- R3: A conversion that does not violate a path's limit restarts that path's run from zero. Cycles without a conversion strobe neither advance the run nor break it.
- R4: The interrupt output is low whenever a status bit is set and its mask bit is 0. Mask bit 0 belongs to the high path and mask bit 1 to the low path; a mask bit of 1 masks the path. The interrupt follows mask changes in the same cycle.
- R5: A masked path still sets its status bit but does not pull the interrupt low.
- R6: While the thermal-alarm input is low, the interrupt output is low in the same cycle, whatever the masks and status bits are.
- R7: Status bits are sticky: they hold until a clear strobe, even if the temperature returns inside its limit. A clear strobe zeroes both status bits on the next cycle.
- R8: After a path sets its status it is disarmed. While disarmed, further violations set nothing, including violations that continue after a clear.
- R9: A disarmed path rearms on the third consecutive conversion that does not violate its limit. A violation during that run restarts it. After rearming, three consecutive violations set the status again.
- R10: If a clear strobe and a status-setting conversion occur in the same cycle, the status bit ends up set.
- R11: After reset, both status bits are 0, both paths are armed with empty runs, and the interrupt is high while the alarm input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| conv_vld | input | 1 | One-cycle strobe marking a new conversion result |
| conv_temp | input | 8 | Signed conversion result |
| lim_hi | input | 8 | Signed high limit |
| lim_lo | input | 8 | Signed low limit |
| src_mask | input | 2 | Per-path mask, bit 0 high path, bit 1 low path, 1 = masked |
| clr | input | 1 | Clear strobe for status and interrupt |
| alarm_n | input | 1 | Active-low thermal-alarm input |
| irq_n | output | 1 | Active-low interrupt |
| stat_o | output | 2 | Sticky status, bit 0 high path, bit 1 low path |

## Verification
The assertions check the properties that hold on every cycle. The interrupt level must always agree with the alarm input, the masks and the status bits. A status bit may only rise on the cycle after a conversion strobe. A clear without a conversion must empty the status, and the status must hold still when there is neither a strobe nor a clear. The rest depends on the history of conversions, so only the bench's scenarios can show it. This covers the three-in-a-row count on each side of the window, a run broken by an in-limit sample, idle cycles that do not break a run, suppression after a clear, rearming, and the clear that collides with a setting conversion.

// File: rtl/templim_pkg.sv
package templim_pkg;
  // Arm state of one limit path
  typedef enum logic {
    ST_ARMED    = 1'b0,
    ST_DISARMED = 1'b1
  } arm_e;

  localparam int unsigned PATH_HI = 0;
  localparam int unsigned PATH_LO = 1;
  localparam int unsigned NPATH   = 2;
endpackage

// File: rtl/templim_rstsync.sv
module templim_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/templim_cmp.sv
// Window comparators: one violation flag per path (R1, R2)
module templim_cmp
  import templim_pkg::*;
#(
  parameter int unsigned TW = 8
) (
  input  logic signed [TW-1:0] temp,
  input  logic signed [TW-1:0] hi,
  input  logic signed [TW-1:0] lo,
  output logic [NPATH-1:0]     viol
);
  always_comb begin
    viol          = '0;
    viol[PATH_HI] = (temp > hi);
    viol[PATH_LO] = (temp < lo);
  end
endmodule

// File: rtl/templim_filt.sv
// Persistence filter for one path: counts violations while armed and
// in-limit samples while disarmed (R3, R8, R9)
module templim_filt
  import templim_pkg::*;
#(
  parameter int unsigned RUN = 3,
  localparam int unsigned CW = (RUN > 2) ? $clog2(RUN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic hit,
  output logic fire
);
  localparam logic [CW-1:0] LAST = CW'(RUN - 1);

  arm_e          st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    fire  = 1'b0;
    if (step) begin
      unique case (st_q)
        ST_ARMED: begin
          if (hit) begin
            if (cnt_q == LAST) begin
              fire  = 1'b1;
              st_d  = ST_DISARMED;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        ST_DISARMED: begin
          if (!hit) begin
            if (cnt_q == LAST) begin
              st_d  = ST_ARMED;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            cnt_d = '0;
          end
        end
        default: begin
          st_d  = ST_ARMED;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_ARMED;
      cnt_q <= '0;
    end else if (step) begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/templim_stat.sv
// Sticky status with clear; a same-cycle set beats the clear (R7, R10)
module templim_stat #(
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] stat
);
  logic [N-1:0] stat_d;
  logic         upd;

  always_comb begin
    stat_d = (clr ? '0 : stat) | set;
    upd    = clr | (|set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (upd) stat <= stat_d;
  end
endmodule

// File: rtl/templim_irqdrv.sv
// Interrupt combine: unmasked status or thermal alarm (R4, R5, R6)
module templim_irqdrv #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] stat,
  input  logic [N-1:0] mask,
  input  logic         alarm_n,
  output logic         irq_n
);
  always_comb begin
    irq_n = ~((|(stat & ~mask)) | ~alarm_n);
  end
endmodule

// File: rtl/templim_irq.sv
module templim_irq
  import templim_pkg::*;
#(
  parameter int unsigned TW  = 8,
  parameter int unsigned RUN = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 conv_vld,
  input  logic signed [TW-1:0] conv_temp,
  input  logic signed [TW-1:0] lim_hi,
  input  logic signed [TW-1:0] lim_lo,
  input  logic [NPATH-1:0]     src_mask,
  input  logic                 clr,
  input  logic                 alarm_n,
  output logic                 irq_n,
  output logic [NPATH-1:0]     stat_o
);
  logic             rst_int_n;
  logic [NPATH-1:0] viol;
  logic [NPATH-1:0] fire;

  templim_rstsync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_int_n)
  );

  templim_cmp #(.TW(TW)) u_cmp (
    .temp (conv_temp),
    .hi   (lim_hi),
    .lo   (lim_lo),
    .viol (viol)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    templim_filt #(.RUN(RUN)) u_filt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .step  (conv_vld),
      .hit   (viol[p]),
      .fire  (fire[p])
    );
  end

  templim_stat #(.N(NPATH)) u_stat (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (fire),
    .clr   (clr),
    .stat  (stat_o)
  );

  templim_irqdrv #(.N(NPATH)) u_irq (
    .stat    (stat_o),
    .mask    (src_mask),
    .alarm_n (alarm_n),
    .irq_n   (irq_n)
  );
endmodule

// File: rtl/templim_irq_chk.sv
module templim_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       conv_vld,
  input logic       clr,
  input logic [1:0] src_mask,
  input logic       alarm_n,
  input logic       irq_n,
  input logic [1:0] stat_o
);
  a_r1_hi_set_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[0]) |-> $past(conv_vld));

  a_r2_lo_set_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_o[1]) |-> $past(conv_vld));

  a_r4_unmasked_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_o & ~src_mask) != 2'b00) |-> !irq_n);

  a_r5_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_n && ((stat_o & ~src_mask) == 2'b00)) |-> irq_n);

  a_r6_alarm_pulls_low: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_n |-> !irq_n);

  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !conv_vld) |=> (stat_o == 2'b00));

  a_r7_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !conv_vld) |=> $stable(stat_o));
endmodule

bind templim_irq templim_irq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .conv_vld (conv_vld),
  .clr      (clr),
  .src_mask (src_mask),
  .alarm_n  (alarm_n),
  .irq_n    (irq_n),
  .stat_o   (stat_o)
);

// File: tb/templim_irq_test.sv
`timescale 1ns/1ps
module templim_irq_test;
  logic              clk;
  logic              rst_n;
  logic              conv_vld;
  logic signed [7:0] conv_temp;
  logic signed [7:0] lim_hi;
  logic signed [7:0] lim_lo;
  logic [1:0]        src_mask;
  logic              clr;
  logic              alarm_n;
  logic              irq_n;
  logic [1:0]        stat_o;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    logic [1:0] stat;
    logic       irq;
    string      tag;
  } exp_t;

  exp_t sb[$];

  templim_irq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_vld  (conv_vld),
    .conv_temp (conv_temp),
    .lim_hi    (lim_hi),
    .lim_lo    (lim_lo),
    .src_mask  (src_mask),
    .clr       (clr),
    .alarm_n   (alarm_n),
    .irq_n     (irq_n),
    .stat_o    (stat_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [1:0] es, logic ei);
    n_chk++;
    if (stat_o !== es || irq_n !== ei) begin
      n_bad++;
      $display("FAIL %s: stat=%b irq_n=%b expected stat=%b irq_n=%b",
               tag, stat_o, irq_n, es, ei);
    end
  endtask

  // Driver: one cycle of stimulus, expected result queued for the monitor
  task automatic op(logic v, int t, logic c, logic [1:0] es, logic ei, string tag);
    exp_t e;
    @(negedge clk);
    conv_vld  = v;
    conv_temp = 8'(t);
    clr       = c;
    e.stat = es;
    e.irq  = ei;
    e.tag  = tag;
    sb.push_back(e);
  endtask

  // Monitor: results are settled 3 ns after the edge that consumed the op
  initial begin
    forever begin
      @(posedge clk);
      #3;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        chk(e.tag, e.stat, e.irq);
      end
    end
  end

  initial begin
    #800000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog all-reqs: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; conv_vld = 1'b0; conv_temp = '0; clr = 1'b0;
    lim_hi = 8'sd40; lim_lo = -8'sd10; src_mask = 2'b00; alarm_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 chk("R11 reset state", 2'b00, 1'b1);

    // A: high path, sticky, clear, suppression, rearm
    op(1, 50, 0, 2'b00, 1, "R1 first hi");
    op(1, 50, 0, 2'b00, 1, "R1 second hi");
    op(1, 50, 0, 2'b01, 0, "R1 third hi sets");
    op(1, 50, 0, 2'b01, 0, "R7 sticky");
    op(0, 0,  1, 2'b00, 1, "R7 clear");
    op(1, 50, 0, 2'b00, 1, "R8 suppressed 1");
    op(1, 50, 0, 2'b00, 1, "R8 suppressed 2");
    op(1, 50, 0, 2'b00, 1, "R8 suppressed 3");
    op(1, 50, 0, 2'b00, 1, "R8 suppressed 4");
    op(1, 20, 0, 2'b00, 1, "R9 rearm run 1");
    op(1, 20, 0, 2'b00, 1, "R9 rearm run 2");
    op(1, 50, 0, 2'b00, 1, "R9 rearm run broken");
    op(1, 20, 0, 2'b00, 1, "R9 rearm 1");
    op(1, 20, 0, 2'b00, 1, "R9 rearm 2");
    op(1, 20, 0, 2'b00, 1, "R9 rearm 3");
    op(1, 50, 0, 2'b00, 1, "R9 hi again 1");
    op(1, 50, 0, 2'b00, 1, "R9 hi again 2");
    op(1, 50, 0, 2'b01, 0, "R9 hi again sets");
    op(0, 0,  1, 2'b00, 1, "R7 clear 2");

    // B: low path, broken run, idle gaps, signed compare
    op(1, -20, 0, 2'b00, 1, "R2 lo 1 / R1 neg not hi");
    op(1, -20, 0, 2'b00, 1, "R2 lo 2");
    op(1, 0,   0, 2'b00, 1, "R3 run broken");
    op(1, -20, 0, 2'b00, 1, "R3 lo restart 1");
    op(1, -20, 0, 2'b00, 1, "R3 lo restart 2");
    op(0, 0,   0, 2'b00, 1, "R3 idle gap 1");
    op(0, 0,   0, 2'b00, 1, "R3 idle gap 2");
    op(1, -20, 0, 2'b10, 0, "R2 R3 lo sets");

    // C: mask
    op(0, 0, 1, 2'b00, 1, "R7 clear 3");
    @(negedge clk); src_mask = 2'b10;
    op(1, 0,   0, 2'b00, 1, "R9 lo rearm 1");
    op(1, 0,   0, 2'b00, 1, "R9 lo rearm 2");
    op(1, 0,   0, 2'b00, 1, "R9 lo rearm 3");
    op(1, -20, 0, 2'b00, 1, "R5 masked lo 1");
    op(1, -20, 0, 2'b00, 1, "R5 masked lo 2");
    op(1, -20, 0, 2'b10, 1, "R5 masked lo sets, irq high");
    @(negedge clk); src_mask = 2'b00;
    op(0, 0, 0, 2'b10, 0, "R4 unmask pulls low");

    // D: clear collides with set
    op(0, 0,  1, 2'b00, 1, "R7 clear 4");
    op(1, 50, 0, 2'b00, 1, "R10 hi 1");
    op(1, 50, 0, 2'b00, 1, "R10 hi 2");
    op(1, 50, 1, 2'b01, 0, "R10 set beats clear");
    op(0, 0,  1, 2'b00, 1, "R7 clear 5");
    @(negedge clk); conv_vld = 1'b0; clr = 1'b0;
    repeat (2) @(negedge clk);

    // E: alarm overrides masks
    src_mask = 2'b11;
    alarm_n  = 1'b0;
    #1 chk("R6 alarm low", 2'b00, 1'b0);
    @(negedge clk);
    alarm_n = 1'b1;
    #1 chk("R6 alarm released", 2'b00, 1'b1);

    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule